// File: doc/BRIEF.md
# Floating-Point Token Bucket Rate Policer

This block polices ingress traffic for a single bandwidth profile. It holds two token buckets: a committed bucket and a peak bucket. For each bucket, the size and the refill amount are given as a mantissa/exponent pair whose value is (1 + mantissa/256) · 2^exponent bytes. Token levels are kept in fixed point with 8 fractional bits, so one count equals 1/256 of a byte.

A free-running base-time pulse (`tick`) arrives from outside. Every 2^rdiv pulses, both buckets are topped up. Each refill saturates at the bucket's ceiling.

For every packet strobe, the block computes a token cost. The cost is the packet length minus a length offset, plus a signed adjust term. In packet mode the length part is dropped, so the cost can be a fixed number of tokens per packet. A two-rate three-color meter then marks the packet green, yellow or red and takes the cost out of the buckets. Each color has its own action code, and that code decides whether the packet passes or is dropped.

Top module: `float_policer`

## Requirements
- R1: A bucket ceiling is (256+m) << e in 1/256-byte units, with m an 8-bit and e a 5-bit field. The pair e = 24, m = 0 gives a ceiling of zero. A refill never leaves a bucket above its ceiling.
- R2: Both buckets are refilled on the 2^rdiv-th `tick` pulse since reset or since the previous refill. The committed bucket gains (256+m) << e from the committed rate pair, and the peak bucket gains the same form from the peak rate pair. rdiv is 4 bits wide.
- R3: A rate exponent above 22 is treated as 22.
- R4: The cost in 1/256-byte units is (len − offset)·256 + (adj_m − 256)·2^adj_e. It is computed signed and is raised to 1 whenever it falls below 1. adj_m is 9 bits and adj_e is 5 bits.
- R5: In packet mode (`cfg_pkt_mode` = 1), the length term is zero. With adj_m = 384 and adj_e = 1, each packet then costs exactly one token (256 units), whatever its length.
- R6: With the peak bucket in use, the meter works as follows. A packet is red if the peak level is below the cost. Otherwise it is yellow if the committed level is below the cost, and yellow takes the cost from the peak bucket only. Otherwise it is green, and green takes the cost from both buckets. Red takes nothing. Color codes are 0 green, 1 yellow, 2 red.
- R7: The peak bucket counts as unused when its size pair is e = 24, m = 0. While it is unused, a packet is green if the committed level covers the cost, and green takes the cost from the committed bucket only. Otherwise the packet is red. A packet is never yellow in this state.
- R8: When `cfg_icolor` is 0, 1 or 2, the meter is color-aware. An incoming red packet is marked red. An incoming yellow packet skips the committed test and cannot be green. When `cfg_icolor` is 3, `pkt_color` has no effect.
- R9: Each color has a 2-bit action field. Code 0 passes the packet and codes 1 to 3 drop it.
- R10: `dec_valid` rises in the cycle after `pkt_valid`, and only then. When a refill and a packet fall in the same cycle, the refill is applied first.
- R11: Reset empties both buckets, clears the refill divider and clears `dec_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Base-time pulse |
| cfg_cbs_mant | input | 8 | Committed size mantissa |
| cfg_cbs_exp | input | 5 | Committed size exponent |
| cfg_cir_mant | input | 8 | Committed refill mantissa |
| cfg_cir_exp | input | 5 | Committed refill exponent |
| cfg_pbs_mant | input | 8 | Peak size mantissa |
| cfg_pbs_exp | input | 5 | Peak size exponent |
| cfg_pir_mant | input | 8 | Peak refill mantissa |
| cfg_pir_exp | input | 5 | Peak refill exponent |
| cfg_rdiv | input | DIV_W | Refill period exponent in ticks |
| cfg_pkt_mode | input | 1 | 1: drop the length term from the cost |
| cfg_adj_mant | input | 9 | Adjust mantissa |
| cfg_adj_exp | input | 5 | Adjust exponent |
| cfg_len_off | input | LEN_W | Bytes subtracted from the length |
| cfg_icolor | input | 2 | 3: color-blind, else color-aware |
| cfg_act_green | input | 2 | Green action, 0 pass |
| cfg_act_yellow | input | 2 | Yellow action, 0 pass |
| cfg_act_red | input | 2 | Red action, 0 pass |
| pkt_valid | input | 1 | Packet strobe |
| pkt_len | input | LEN_W | Packet length in bytes |
| pkt_color | input | 2 | Incoming packet color |
| dec_valid | output | 1 | Decision strobe |
| dec_color | output | 2 | Assigned color |
| dec_pass | output | 1 | 1 pass, 0 drop |

## Verification
The verdict on a packet is due exactly one clock after its strobe, because there is a single decision register. Bucket changes from that packet first show up in the verdict on the next packet. A refill raised by a tick becomes visible in the verdict on a packet presented in that same cycle. The bench drives each cycle at the falling edge and moves a behavioural model forward with the same inputs. At the next falling edge it compares the valid flag, the color and the pass bit against that model, so every cycle is checked against the verdict due in it.

// File: rtl/policer_pkg.sv
package policer_pkg;

    // Token levels: 1/256-byte units; wide enough for (511 << 31) plus one refill.
    localparam int FX_W         = 48;
    localparam int RATE_EXP_MAX = 22;
    localparam int UNUSED_EXP   = 24;

    typedef enum logic [1:0] {
        CLR_GREEN  = 2'd0,
        CLR_YELLOW = 2'd1,
        CLR_RED    = 2'd2
    } color_e;

    typedef struct packed {
        logic [7:0] mant;
        logic [4:0] expo;
    } flt_t;

    typedef struct packed {
        logic       valid;
        color_e     color;
        logic       pass;
    } verdict_t;

    typedef logic signed [FX_W+1:0] sfx_t;

    function automatic logic is_unused(input flt_t f);
        return (f.expo == 5'(UNUSED_EXP)) && (f.mant == 8'd0);
    endfunction

    function automatic logic [FX_W-1:0] size_fx(input flt_t f);
        if (is_unused(f))
            return '0;
        return FX_W'({1'b1, f.mant}) << f.expo;
    endfunction

    function automatic logic [FX_W-1:0] rate_fx(input flt_t f);
        logic [4:0] e;
        e = (f.expo > 5'(RATE_EXP_MAX)) ? 5'(RATE_EXP_MAX) : f.expo;
        return FX_W'({1'b1, f.mant}) << e;
    endfunction

    function automatic logic [FX_W-1:0] token_cost(
        input logic [31:0] len,
        input logic [31:0] off,
        input logic        pkt_mode,
        input logic [8:0]  adj_m,
        input logic [4:0]  adj_e
    );
        sfx_t body, adj, total;
        body  = pkt_mode ? sfx_t'(0) : ((sfx_t'(len) - sfx_t'(off)) <<< 8);
        adj   = (sfx_t'(adj_m) - sfx_t'(256)) <<< adj_e;
        total = body + adj;
        if (total < sfx_t'(1))
            return FX_W'(1);
        return total[FX_W-1:0];
    endfunction

endpackage

// File: rtl/pol_tick_div.sv
module pol_tick_div #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [DIV_W-1:0] rdiv,
    output logic             refill
);
    localparam int CNT_W = (1 << DIV_W);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    assign limit  = (CNT_W'(1) << rdiv) - CNT_W'(1);
    assign refill = tick && (cnt_q >= limit);

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= refill ? '0 : cnt_q + CNT_W'(1);
    end

    // After a refill with a divider above one, the next tick cannot refill again.
    assert_refill_spacing_R2: assert property (@(posedge clk) disable iff (rst)
        (refill && rdiv != '0) |=> !(refill && $stable(rdiv)));

endmodule

// File: rtl/pol_bucket.sv
module pol_bucket
    import policer_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            refill,
    input  logic [FX_W-1:0] add_fx,
    input  logic [FX_W-1:0] ceil_fx,
    input  logic            debit_en,
    input  logic [FX_W-1:0] debit_fx,
    output logic [FX_W-1:0] avail
);
    logic [FX_W-1:0] level_q;
    logic [FX_W:0]   sum;

    assign sum   = {1'b0, level_q} + {1'b0, add_fx};
    assign avail = !refill ? level_q
                 : (sum > {1'b0, ceil_fx}) ? ceil_fx : sum[FX_W-1:0];

    always_ff @(posedge clk) begin
        if (rst)
            level_q <= '0;
        else if (debit_en)
            level_q <= avail - debit_fx;
        else
            level_q <= avail;
    end

    assert_debit_covered_R6: assert property (@(posedge clk) disable iff (rst)
        debit_en |-> (debit_fx <= avail));

    assert_no_overflow_R1: assert property (@(posedge clk) disable iff (rst)
        (refill && !debit_en) |=> (level_q <= $past(ceil_fx)));

endmodule

// File: rtl/pol_meter.sv
module pol_meter
    import policer_pkg::*;
(
    input  logic [FX_W-1:0] avail_c,
    input  logic [FX_W-1:0] avail_p,
    input  logic [FX_W-1:0] cost,
    input  logic            peak_unused,
    input  logic            blind,
    input  logic [1:0]      pkt_color,
    output color_e          color,
    output logic            take_c,
    output logic            take_p
);
    logic in_red, in_yel;

    assign in_red = !blind && (pkt_color == 2'(CLR_RED));
    assign in_yel = !blind && (pkt_color == 2'(CLR_YELLOW));

    always_comb begin
        color  = CLR_RED;
        take_c = 1'b0;
        take_p = 1'b0;
        if (peak_unused) begin
            if (!in_red && !in_yel && avail_c >= cost) begin
                color  = CLR_GREEN;
                take_c = 1'b1;
            end
        end else if (!in_red && avail_p >= cost) begin
            take_p = 1'b1;
            if (in_yel || avail_c < cost) begin
                color = CLR_YELLOW;
            end else begin
                color  = CLR_GREEN;
                take_c = 1'b1;
            end
        end
    end

endmodule

// File: rtl/float_policer.sv
module float_policer
    import policer_pkg::*;
#(
    parameter int LEN_W = 16,
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [7:0]       cfg_cbs_mant,
    input  logic [4:0]       cfg_cbs_exp,
    input  logic [7:0]       cfg_cir_mant,
    input  logic [4:0]       cfg_cir_exp,
    input  logic [7:0]       cfg_pbs_mant,
    input  logic [4:0]       cfg_pbs_exp,
    input  logic [7:0]       cfg_pir_mant,
    input  logic [4:0]       cfg_pir_exp,
    input  logic [DIV_W-1:0] cfg_rdiv,
    input  logic             cfg_pkt_mode,
    input  logic [8:0]       cfg_adj_mant,
    input  logic [4:0]       cfg_adj_exp,
    input  logic [LEN_W-1:0] cfg_len_off,
    input  logic [1:0]       cfg_icolor,
    input  logic [1:0]       cfg_act_green,
    input  logic [1:0]       cfg_act_yellow,
    input  logic [1:0]       cfg_act_red,
    input  logic             pkt_valid,
    input  logic [LEN_W-1:0] pkt_len,
    input  logic [1:0]       pkt_color,
    output logic             dec_valid,
    output logic [1:0]       dec_color,
    output logic             dec_pass
);
    localparam int NB = 2;   // 0: committed, 1: peak

    logic            refill;
    logic [FX_W-1:0] cost;
    logic            peak_unused;
    color_e          color;
    logic            take_c, take_p;
    logic [FX_W-1:0] b_add  [NB];
    logic [FX_W-1:0] b_ceil [NB];
    logic [FX_W-1:0] b_avail[NB];
    logic            b_take [NB];
    logic [1:0]      act;
    verdict_t        dec_q;

    assign b_add[0]  = rate_fx('{mant: cfg_cir_mant, expo: cfg_cir_exp});
    assign b_add[1]  = rate_fx('{mant: cfg_pir_mant, expo: cfg_pir_exp});
    assign b_ceil[0] = size_fx('{mant: cfg_cbs_mant, expo: cfg_cbs_exp});
    assign b_ceil[1] = size_fx('{mant: cfg_pbs_mant, expo: cfg_pbs_exp});
    assign b_take[0] = pkt_valid && take_c;
    assign b_take[1] = pkt_valid && take_p;

    assign peak_unused = is_unused('{mant: cfg_pbs_mant, expo: cfg_pbs_exp});
    assign cost = token_cost(32'(pkt_len), 32'(cfg_len_off), cfg_pkt_mode,
                             cfg_adj_mant, cfg_adj_exp);

    pol_tick_div #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst(rst), .tick(tick), .rdiv(cfg_rdiv), .refill(refill)
    );

    for (genvar i = 0; i < NB; i++) begin : g_bucket
        pol_bucket u_bucket (
            .clk     (clk),
            .rst     (rst),
            .refill  (refill),
            .add_fx  (b_add[i]),
            .ceil_fx (b_ceil[i]),
            .debit_en(b_take[i]),
            .debit_fx(cost),
            .avail   (b_avail[i])
        );
    end

    pol_meter u_meter (
        .avail_c    (b_avail[0]),
        .avail_p    (b_avail[1]),
        .cost       (cost),
        .peak_unused(peak_unused),
        .blind      (cfg_icolor == 2'd3),
        .pkt_color  (pkt_color),
        .color      (color),
        .take_c     (take_c),
        .take_p     (take_p)
    );

    always_comb begin
        unique case (color)
            CLR_GREEN:  act = cfg_act_green;
            CLR_YELLOW: act = cfg_act_yellow;
            default:    act = cfg_act_red;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_q <= '{valid: 1'b0, color: CLR_GREEN, pass: 1'b0};
        end else begin
            dec_q.valid <= pkt_valid;
            if (pkt_valid) begin
                dec_q.color <= color;
                dec_q.pass  <= (act == 2'd0);
            end
        end
    end

    assign dec_valid = dec_q.valid;
    assign dec_color = dec_q.color;
    assign dec_pass  = dec_q.pass;

    assert_latency_R10: assert property (@(posedge clk) disable iff (rst)
        pkt_valid |=> dec_valid);

    assert_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !pkt_valid |=> !dec_valid);

    assert_two_color_R7: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && peak_unused) |=> (dec_color != 2'(CLR_YELLOW)));

    assert_min_cost_R4: assert property (@(posedge clk) disable iff (rst)
        pkt_valid |-> (cost != '0));

    assert_green_action_R9: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && color == CLR_GREEN && cfg_act_green != 2'd0) |=> !dec_pass);

endmodule

// File: tb/tb_float_policer.sv
module tb_float_policer;
    localparam int CLK_PERIOD = 10;
    localparam int LEN_W = 16;
    localparam int DIV_W = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0;
    logic [7:0] cbs_m = 0, cir_m = 0, pbs_m = 0, pir_m = 0;
    logic [4:0] cbs_e = 0, cir_e = 0, pbs_e = 0, pir_e = 0;
    logic [DIV_W-1:0] rdiv = 0;
    logic pkt_mode = 0;
    logic [8:0] adj_m = 9'd256;
    logic [4:0] adj_e = 0;
    logic [LEN_W-1:0] len_off = 0;
    logic [1:0] icolor = 2'd3;
    logic [1:0] act_g = 0, act_y = 0, act_r = 2'd1;
    logic pkt_valid = 0;
    logic [LEN_W-1:0] pkt_len = 0;
    logic [1:0] pkt_color = 0;
    logic dec_valid, dec_pass;
    logic [1:0] dec_color;

    int checks = 0;
    int errors = 0;

    longint m_tc, m_tp;
    longint m_cnt;
    bit     e_valid;
    int     e_color;
    bit     e_pass;

    always #(CLK_PERIOD/2) clk = ~clk;

    float_policer #(.LEN_W(LEN_W), .DIV_W(DIV_W)) dut (
        .clk(clk), .rst(rst), .tick(tick),
        .cfg_cbs_mant(cbs_m), .cfg_cbs_exp(cbs_e),
        .cfg_cir_mant(cir_m), .cfg_cir_exp(cir_e),
        .cfg_pbs_mant(pbs_m), .cfg_pbs_exp(pbs_e),
        .cfg_pir_mant(pir_m), .cfg_pir_exp(pir_e),
        .cfg_rdiv(rdiv), .cfg_pkt_mode(pkt_mode),
        .cfg_adj_mant(adj_m), .cfg_adj_exp(adj_e),
        .cfg_len_off(len_off), .cfg_icolor(icolor),
        .cfg_act_green(act_g), .cfg_act_yellow(act_y), .cfg_act_red(act_r),
        .pkt_valid(pkt_valid), .pkt_len(pkt_len), .pkt_color(pkt_color),
        .dec_valid(dec_valid), .dec_color(dec_color), .dec_pass(dec_pass)
    );

    function automatic longint size_of(int m, int e);
        if (e == 24 && m == 0) return 0;
        return longint'(256 + m) <<< e;
    endfunction

    function automatic longint rate_of(int m, int e);
        return longint'(256 + m) <<< ((e > 22) ? 22 : e);
    endfunction

    function automatic longint min2(longint a, longint b);
        return (a < b) ? a : b;
    endfunction

    // Behavioural reference: one call per clock, using the inputs of that cycle.
    task automatic model_step();
        longint cost, c_ceil, p_ceil;
        bit unused, refill;
        int in_c, act;
        if (rst) begin
            m_tc = 0; m_tp = 0; m_cnt = 0; e_valid = 0;
            return;
        end
        c_ceil = size_of(cbs_m, cbs_e);
        p_ceil = size_of(pbs_m, pbs_e);
        unused = (pbs_e == 24 && pbs_m == 0);
        refill = tick && (m_cnt >= (longint'(1) <<< rdiv) - 1);
        if (tick) m_cnt = refill ? 0 : m_cnt + 1;
        if (refill) begin
            m_tc = min2(m_tc + rate_of(cir_m, cir_e), c_ceil);
            m_tp = min2(m_tp + rate_of(pir_m, pir_e), p_ceil);
        end
        e_valid = pkt_valid;
        if (pkt_valid) begin
            cost = (pkt_mode ? 0 : (longint'(pkt_len) - longint'(len_off)) * 256)
                 + (longint'(adj_m) - 256) * (longint'(1) <<< adj_e);
            if (cost < 1) cost = 1;
            in_c = (icolor == 3) ? 0 : int'(pkt_color);
            if (unused) begin
                if (in_c != 2 && in_c != 1 && m_tc >= cost) begin
                    e_color = 0; m_tc -= cost;
                end else e_color = 2;
            end else if (in_c == 2 || m_tp < cost) begin
                e_color = 2;
            end else if (in_c == 1 || m_tc < cost) begin
                e_color = 1; m_tp -= cost;
            end else begin
                e_color = 0; m_tc -= cost; m_tp -= cost;
            end
            act = (e_color == 0) ? int'(act_g) : (e_color == 1) ? int'(act_y) : int'(act_r);
            e_pass = (act == 0);
        end
    endtask

    task automatic compare(input string tag);
        checks++;
        if (dec_valid !== e_valid) begin
            errors++;
            $display("FAIL %s: dec_valid actual %0b expected %0b", tag, dec_valid, e_valid);
        end
        if (e_valid) begin
            checks++;
            if (dec_color !== 2'(e_color)) begin
                errors++;
                $display("FAIL %s: dec_color actual %0d expected %0d", tag, dec_color, e_color);
            end
            checks++;
            if (dec_pass !== e_pass) begin
                errors++;
                $display("FAIL %s: dec_pass actual %0b expected %0b", tag, dec_pass, e_pass);
            end
        end
    endtask

    // Called at a falling edge; drives one cycle and checks its verdict at the next.
    task automatic step(input string tag, input bit tk, input bit pv,
                        input int len, input logic [1:0] pc);
        tick = tk; pkt_valid = pv; pkt_len = LEN_W'(len); pkt_color = pc;
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic do_reset(input string tag);
        rst = 1'b1;
        step(tag, 0, 0, 0, 0);
        step(tag, 0, 0, 0, 0);
        rst = 1'b0;
    endtask

    task automatic ticks(input string tag, input int n);
        for (int i = 0; i < n; i++) step(tag, 1, 0, 0, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R11: reset state, then empty buckets make the first packet red
        do_reset("R11");
        cbs_e = 10; pbs_e = 11; cir_e = 8; pir_e = 9;
        step("R11", 0, 1, 10, 0);

        // R1 R6: fill to ceilings, then drain through green, yellow, red
        ticks("R1", 10);
        for (int i = 0; i < 7; i++) step("R6", 0, 1, 300, 0);

        // R8: color-aware input colors, then blind mode ignores them
        ticks("R8", 10);
        icolor = 2'd0;
        step("R8", 0, 1, 100, 2'd2);
        step("R8", 0, 1, 100, 2'd1);
        step("R8", 0, 1, 100, 2'd0);
        icolor = 2'd3;
        step("R8", 0, 1, 100, 2'd2);
        step("R8", 0, 1, 100, 2'd1);

        // R9: per-color actions
        act_g = 2'd1; act_y = 2'd0; act_r = 2'd2;
        ticks("R9", 10);
        for (int i = 0; i < 7; i++) step("R9", 0, 1, 300, 0);
        act_g = 2'd0; act_y = 2'd3; act_r = 2'd0;
        ticks("R9", 10);
        for (int i = 0; i < 7; i++) step("R9", 0, 1, 300, 0);
        act_g = 0; act_y = 0; act_r = 2'd1;

        // R7: unused peak gives two colors only
        do_reset("R7");
        pbs_e = 24; pbs_m = 0; cbs_e = 10; cir_e = 8;
        ticks("R7", 4);
        for (int i = 0; i < 5; i++) step("R7", 0, 1, 300, 0);
        ticks("R7", 4);
        icolor = 2'd0;
        step("R7", 0, 1, 10, 2'd1);
        step("R7", 0, 1, 10, 2'd0);
        icolor = 2'd3;

        // R3: rate exponent 30 behaves as 22
        do_reset("R3");
        cbs_e = 25; cir_e = 30; adj_m = 9'd511; adj_e = 23;
        ticks("R3", 1);
        step("R3", 0, 1, 0, 0);
        ticks("R3", 3);
        step("R3", 0, 1, 0, 0);
        adj_m = 9'd256; adj_e = 0;

        // R4: negative cost is raised to 1/256 byte; 256 such packets empty one byte
        do_reset("R4");
        cbs_e = 0; cbs_m = 0; cir_e = 0; cir_m = 0; len_off = 20;
        ticks("R4", 1);
        for (int i = 0; i < 257; i++) step("R4", 0, 1, 10, 0);
        len_off = 0;

        // R5: packet mode, one token per packet regardless of length
        do_reset("R5");
        cbs_e = 1; cir_e = 0; pkt_mode = 1; adj_m = 9'd384; adj_e = 1;
        ticks("R5", 2);
        step("R5", 0, 1, 1500, 0);
        step("R5", 0, 1, 9000, 0);
        step("R5", 0, 1, 64, 0);
        pkt_mode = 0; adj_m = 9'd256; adj_e = 0;

        // R2: refill only on every 4th tick with rdiv = 2
        do_reset("R2");
        cbs_e = 10; cir_e = 8; rdiv = 2;
        ticks("R2", 3);
        step("R2", 0, 1, 100, 0);
        ticks("R2", 1);
        step("R2", 0, 1, 100, 0);
        ticks("R2", 3);
        step("R2", 0, 1, 100, 0);
        rdiv = 0;

        // R10: refill and packet in one cycle, refill first
        do_reset("R10");
        cbs_e = 10; cir_e = 8;
        step("R10", 1, 1, 200, 0);
        step("R10", 0, 0, 0, 0);
        step("R10", 1, 1, 300, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule